// File: doc/BRIEF.md
# Interrupt Event Notification Sequencer

This block carries one interrupt event through the decision chain of an event-notification descriptor. A trigger names a descriptor by block and index and carries event data. The sequencer requests the descriptor, then works through its stages in order. It checks that the descriptor is valid. It optionally queues the data. A silent descriptor jumps ahead to escalation. In format 0 a priority of all ones masks the event. Optional coalescing uses a two-bit notification state. The block then asks the presenter for a dispatched thread. If none is found, it can record a backlog bit for a virtual processor. Finally it can escalate, which feeds the trigger back into the same chain with a second descriptor.

Descriptor storage, the presenter and the queue writer are outside the block. It talks to each of them through a request and acknowledge pair or through single-cycle strobes. One event is handled at a time. An escalation runs only one level deep.

Top module: `evnt_sequencer`

## Requirements
- R1: A fetched descriptor whose valid flag is 0 ends the sequence with `err_valid`, `err_code` = 1 and `done` in the same cycle. No queueing, write-back, presentation or escalation follows.
- R2: With the queue flag set on a valid descriptor, `enq_valid` pulses with `enq_data` equal to the event data. This happens in the decision cycle that follows the fetch acknowledge, before any presentation request.
- R3: With the silent flag set, no presentation request is made and the sequence continues directly at the escalation stage.
- R4: With the silent flag clear, format 0 (`desc_format` = 0) and priority equal to all ones, the sequence ends with `done`. There is no write-back and no presentation.
- R5: With the direct flag clear, the notification state (bit 1 = P, bit 0 = Q) steps as a trigger: 00→10 continues, 10→11, 11→11 and 01→11 stop with `done`. When the state changes, `wb_valid` pulses and carries both states.
- R6: When the presenter reports not found, backlog is set and format is 0, `bl_valid` pulses with `bl_mask` bit (7 − priority) set for priorities 0..7 and zero otherwise.
- R7: When the presenter reports not found with backlog set and format 1, the sequence ends with `err_code` = 2 and `done`.
- R8: When the presenter reports found, the sequence ends with `done` and no escalation.
- R9: Escalation occurs only with the escalate flag set. Unless the unconditional flag is set, the escalation state steps under the R5 encoding and is written back when it changes. Only the 00 state lets escalation proceed.
- R10: An escalation pulses `esc_valid` with the descriptor's escalation block, index and data. It then fetches that descriptor and reruns the sequence with that data.
- R11: An escalation that would start from an already escalated sequence ends with `err_code` = 3 and `done`.
- R12: After reset the block is idle, with `busy`, the requests and all strobes low. A trigger is accepted only while idle, and `done` is seen only with `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_valid | input | 1 | Event trigger strobe |
| trig_blk | input | BLK_W | Descriptor block of the trigger |
| trig_idx | input | IDX_W | Descriptor index of the trigger |
| trig_data | input | DATA_W | Event data |
| busy | output | 1 | A sequence is in progress |
| fetch_req | output | 1 | Descriptor fetch request |
| fetch_blk | output | BLK_W | Block to fetch |
| fetch_idx | output | IDX_W | Index to fetch |
| fetch_ack | input | 1 | Descriptor fields are valid |
| desc_valid | input | 1 | Descriptor valid flag |
| desc_enq | input | 1 | Queue the event data |
| desc_silent | input | 1 | Skip notification, go to escalation |
| desc_direct | input | 1 | Bypass notification coalescing |
| desc_backlog | input | 1 | Record backlog when not found |
| desc_escalate | input | 1 | Escalation enabled |
| desc_uncond | input | 1 | Escalate without coalescing |
| desc_format | input | 1 | Notification format (0 or 1) |
| desc_prio | input | PRIO_W | Notification priority |
| desc_npq | input | 2 | Notification coalescing state |
| desc_epq | input | 2 | Escalation coalescing state |
| desc_esc_blk | input | BLK_W | Escalation target block |
| desc_esc_idx | input | IDX_W | Escalation target index |
| desc_esc_data | input | DATA_W | Escalation event data |
| enq_valid | output | 1 | Queue request strobe |
| enq_data | output | DATA_W | Data to queue |
| wb_valid | output | 1 | Descriptor state write-back strobe |
| wb_blk | output | BLK_W | Write-back block |
| wb_idx | output | IDX_W | Write-back index |
| wb_npq | output | 2 | New notification state |
| wb_epq | output | 2 | New escalation state |
| pres_req | output | 1 | Presentation request |
| pres_ack | input | 1 | Presenter answer strobe |
| pres_found | input | 1 | A dispatched thread matched |
| bl_valid | output | 1 | Backlog update strobe |
| bl_mask | output | MASK_W | Pending-priority bit to OR in |
| esc_valid | output | 1 | Escalation re-trigger strobe |
| esc_blk | output | BLK_W | Escalation block |
| esc_idx | output | IDX_W | Escalation index |
| esc_data | output | DATA_W | Escalation data |
| done | output | 1 | Sequence finished |
| err_valid | output | 1 | Sequence ended in error |
| err_code | output | 2 | 1 invalid, 2 backlog with format 1, 3 escalation depth |

## Verification
Two pairs of functions can land in the same cycle. The queue strobe and the notification write-back can both come from the decision cycle. The escalation write-back can coincide with either the escalation re-trigger or the stopping `done`. The bench provokes the first pair with a descriptor that has queueing on and a 00 notification state. It provokes the second with a descriptor that escalates conditionally from 00 and then from 10. A monitor gathers every strobe into one record per cycle, and these are compared with records built by a behavioural model. A pair split across two cycles, or a missing half of a pair, therefore shows as a mismatch.

// File: rtl/evseq_pkg.sv
// Shared types of the event notification sequencer.
package evseq_pkg;

    // Sequencer stages
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECIDE,
        ST_PRESENT,
        ST_ESCAL
    } seq_state_t;

    // Per-descriptor control flags latched at fetch
    typedef struct packed {
        logic vld;
        logic enq;
        logic sil;
        logic dir;
        logic bkl;
        logic esc;
        logic unc;
        logic fmt;
    } desc_flags_t;

    localparam logic [1:0] ERR_NONE    = 2'd0;
    localparam logic [1:0] ERR_INVALID = 2'd1;
    localparam logic [1:0] ERR_BKLCFG  = 2'd2;
    localparam logic [1:0] ERR_DEPTH   = 2'd3;

endpackage

// File: rtl/evseq_pq_step.sv
// Two-bit coalescing state step for a trigger.
// Assumes bit 1 is P and bit 0 is Q; only the 00 state lets the event pass.
module evseq_pq_step (
    input  logic [1:0] cur,
    output logic [1:0] nxt,
    output logic       fire
);
    // Trigger: P always set, Q set if anything was already pending
    always_comb begin
        nxt  = {1'b1, cur[1] | cur[0]};
        fire = (cur == 2'b00);
    end
endmodule

// File: rtl/evseq_prio_mask.sv
// Converts a priority into a one-hot pending mask, priority 0 at the MSB.
// Assumes priorities at or above MASK_W map to an all-zero mask.
module evseq_prio_mask #(
    parameter int unsigned PRIO_W = 8,
    parameter int unsigned MASK_W = 8
) (
    input  logic [PRIO_W-1:0] prio,
    output logic [MASK_W-1:0] mask
);
    // One comparator per mask bit
    for (genvar b = 0; b < MASK_W; b++) begin : g_bit
        localparam int unsigned POS = MASK_W - 1 - b;
        assign mask[b] = (prio == PRIO_W'(POS));
    end
endmodule

// File: rtl/evnt_sequencer.sv
// Event notification sequencer: fetches a descriptor for a trigger, then
// walks validity, queueing, silent/mask checks, notification coalescing,
// presentation, backlog and escalation. Assumes one event in flight and
// descriptor fields stable while fetch_ack is high.
module evnt_sequencer #(
    parameter int unsigned BLK_W  = 4,
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned DATA_W = 31,
    parameter int unsigned PRIO_W = 8,
    parameter int unsigned MASK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_valid,
    input  logic [BLK_W-1:0]  trig_blk,
    input  logic [IDX_W-1:0]  trig_idx,
    input  logic [DATA_W-1:0] trig_data,
    output logic              busy,
    output logic              fetch_req,
    output logic [BLK_W-1:0]  fetch_blk,
    output logic [IDX_W-1:0]  fetch_idx,
    input  logic              fetch_ack,
    input  logic              desc_valid,
    input  logic              desc_enq,
    input  logic              desc_silent,
    input  logic              desc_direct,
    input  logic              desc_backlog,
    input  logic              desc_escalate,
    input  logic              desc_uncond,
    input  logic              desc_format,
    input  logic [PRIO_W-1:0] desc_prio,
    input  logic [1:0]        desc_npq,
    input  logic [1:0]        desc_epq,
    input  logic [BLK_W-1:0]  desc_esc_blk,
    input  logic [IDX_W-1:0]  desc_esc_idx,
    input  logic [DATA_W-1:0] desc_esc_data,
    output logic              enq_valid,
    output logic [DATA_W-1:0] enq_data,
    output logic              wb_valid,
    output logic [BLK_W-1:0]  wb_blk,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [1:0]        wb_npq,
    output logic [1:0]        wb_epq,
    output logic              pres_req,
    input  logic              pres_ack,
    input  logic              pres_found,
    output logic              bl_valid,
    output logic [MASK_W-1:0] bl_mask,
    output logic              esc_valid,
    output logic [BLK_W-1:0]  esc_blk,
    output logic [IDX_W-1:0]  esc_idx,
    output logic [DATA_W-1:0] esc_data,
    output logic              done,
    output logic              err_valid,
    output logic [1:0]        err_code
);
    import evseq_pkg::*;

    localparam logic [PRIO_W-1:0] PRIO_MASKED = {PRIO_W{1'b1}};

    seq_state_t        state;
    logic [BLK_W-1:0]  cur_blk;
    logic [IDX_W-1:0]  cur_idx;
    logic [DATA_W-1:0] cur_data;
    logic              lvl;
    desc_flags_t       flg;
    logic [PRIO_W-1:0] prio_q;
    logic [1:0]        npq_q, epq_q;
    logic [BLK_W-1:0]  eblk_q;
    logic [IDX_W-1:0]  eidx_q;
    logic [DATA_W-1:0] edata_q;

    logic [1:0]        n_nxt, e_nxt;
    logic              n_fire, e_fire, esc_pass;
    logic [MASK_W-1:0] prio_mask;

    evseq_pq_step u_npq (.cur(npq_q), .nxt(n_nxt), .fire(n_fire));
    evseq_pq_step u_epq (.cur(epq_q), .nxt(e_nxt), .fire(e_fire));

    evseq_prio_mask #(.PRIO_W(PRIO_W), .MASK_W(MASK_W)) u_mask (
        .prio (prio_q),
        .mask (prio_mask)
    );

    // Stage-derived request lines and fetch address
    always_comb begin
        busy      = (state != ST_IDLE);
        fetch_req = (state == ST_FETCH);
        pres_req  = (state == ST_PRESENT);
        fetch_blk = cur_blk;
        fetch_idx = cur_idx;
        esc_pass  = flg.unc | e_fire;
    end

    // Sequencer state, latched descriptor and registered strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cur_blk   <= '0;
            cur_idx   <= '0;
            cur_data  <= '0;
            lvl       <= 1'b0;
            flg       <= '0;
            prio_q    <= '0;
            npq_q     <= '0;
            epq_q     <= '0;
            eblk_q    <= '0;
            eidx_q    <= '0;
            edata_q   <= '0;
            enq_valid <= 1'b0;
            enq_data  <= '0;
            wb_valid  <= 1'b0;
            wb_blk    <= '0;
            wb_idx    <= '0;
            wb_npq    <= '0;
            wb_epq    <= '0;
            bl_valid  <= 1'b0;
            bl_mask   <= '0;
            esc_valid <= 1'b0;
            esc_blk   <= '0;
            esc_idx   <= '0;
            esc_data  <= '0;
            done      <= 1'b0;
            err_valid <= 1'b0;
            err_code  <= ERR_NONE;
        end else begin
            enq_valid <= 1'b0;
            wb_valid  <= 1'b0;
            bl_valid  <= 1'b0;
            esc_valid <= 1'b0;
            done      <= 1'b0;
            err_valid <= 1'b0;
            err_code  <= ERR_NONE;
            case (state)
                ST_IDLE: begin
                    if (trig_valid) begin
                        cur_blk  <= trig_blk;
                        cur_idx  <= trig_idx;
                        cur_data <= trig_data;
                        lvl      <= 1'b0;
                        state    <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (fetch_ack) begin
                        flg     <= '{vld: desc_valid, enq: desc_enq, sil: desc_silent,
                                     dir: desc_direct, bkl: desc_backlog,
                                     esc: desc_escalate, unc: desc_uncond,
                                     fmt: desc_format};
                        prio_q  <= desc_prio;
                        npq_q   <= desc_npq;
                        epq_q   <= desc_epq;
                        eblk_q  <= desc_esc_blk;
                        eidx_q  <= desc_esc_idx;
                        edata_q <= desc_esc_data;
                        state   <= ST_DECIDE;
                    end
                end
                ST_DECIDE: begin
                    if (!flg.vld) begin
                        err_valid <= 1'b1;
                        err_code  <= ERR_INVALID;
                        done      <= 1'b1;
                        state     <= ST_IDLE;
                    end else begin
                        if (flg.enq) begin
                            enq_valid <= 1'b1;
                            enq_data  <= cur_data;
                        end
                        if (flg.sil) begin
                            state <= ST_ESCAL;
                        end else if (!flg.fmt && prio_q == PRIO_MASKED) begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else if (!flg.dir) begin
                            if (n_nxt != npq_q) begin
                                wb_valid <= 1'b1;
                                wb_blk   <= cur_blk;
                                wb_idx   <= cur_idx;
                                wb_npq   <= n_nxt;
                                wb_epq   <= epq_q;
                                npq_q    <= n_nxt;
                            end
                            if (n_fire) begin
                                state <= ST_PRESENT;
                            end else begin
                                done  <= 1'b1;
                                state <= ST_IDLE;
                            end
                        end else begin
                            state <= ST_PRESENT;
                        end
                    end
                end
                ST_PRESENT: begin
                    if (pres_ack) begin
                        if (pres_found) begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else if (flg.bkl && flg.fmt) begin
                            err_valid <= 1'b1;
                            err_code  <= ERR_BKLCFG;
                            done      <= 1'b1;
                            state     <= ST_IDLE;
                        end else begin
                            if (flg.bkl) begin
                                bl_valid <= 1'b1;
                                bl_mask  <= prio_mask;
                            end
                            state <= ST_ESCAL;
                        end
                    end
                end
                ST_ESCAL: begin
                    if (!flg.esc) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        if (!flg.unc && e_nxt != epq_q) begin
                            wb_valid <= 1'b1;
                            wb_blk   <= cur_blk;
                            wb_idx   <= cur_idx;
                            wb_npq   <= npq_q;
                            wb_epq   <= e_nxt;
                            epq_q    <= e_nxt;
                        end
                        if (!esc_pass) begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else if (lvl) begin
                            err_valid <= 1'b1;
                            err_code  <= ERR_DEPTH;
                            done      <= 1'b1;
                            state     <= ST_IDLE;
                        end else begin
                            esc_valid <= 1'b1;
                            esc_blk   <= eblk_q;
                            esc_idx   <= eidx_q;
                            esc_data  <= edata_q;
                            cur_blk   <= eblk_q;
                            cur_idx   <= eidx_q;
                            cur_data  <= edata_q;
                            lvl       <= 1'b1;
                            state     <= ST_FETCH;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/evseq_chk.sv
// Checker for the event notification sequencer, bound to its top.
// Assumes synchronous active-low reset; every property is disabled in reset.
module evseq_chk #(
    parameter int unsigned BLK_W  = 4,
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned MASK_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              fetch_req,
    input logic [BLK_W-1:0]  fetch_blk,
    input logic [IDX_W-1:0]  fetch_idx,
    input logic              enq_valid,
    input logic              wb_valid,
    input logic [1:0]        wb_npq,
    input logic [1:0]        wb_epq,
    input logic              bl_valid,
    input logic [MASK_W-1:0] bl_mask,
    input logic              esc_valid,
    input logic [BLK_W-1:0]  esc_blk,
    input logic [IDX_W-1:0]  esc_idx,
    input logic              done,
    input logic              err_valid
);
    p_err_ends_r1: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> done);

    p_enq_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
        enq_valid |=> !enq_valid);

    p_wb_sets_p_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_npq[1] || wb_epq[1]));

    p_bl_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bl_valid |-> $onehot0(bl_mask));

    p_esc_refetch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        esc_valid |-> (fetch_req && fetch_idx == esc_idx && fetch_blk == esc_blk));

    p_esc_not_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        esc_valid |-> !done);

    p_fetch_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> busy);

    p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind evnt_sequencer evseq_chk #(.BLK_W(BLK_W), .IDX_W(IDX_W), .MASK_W(MASK_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .fetch_req (fetch_req),
    .fetch_blk (fetch_blk),
    .fetch_idx (fetch_idx),
    .enq_valid (enq_valid),
    .wb_valid  (wb_valid),
    .wb_npq    (wb_npq),
    .wb_epq    (wb_epq),
    .bl_valid  (bl_valid),
    .bl_mask   (bl_mask),
    .esc_valid (esc_valid),
    .esc_blk   (esc_blk),
    .esc_idx   (esc_idx),
    .done      (done),
    .err_valid (err_valid)
);

// File: tb/evnt_sequencer_test.sv
// Bench: descriptor store and presenter responders, a per-cycle strobe
// monitor, and a behavioural model producing the expected strobe records.
module evnt_sequencer_test;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic vld, enq, sil, dir, bkl, esc, unc, fmt;
        logic [7:0]  prio;
        logic [1:0]  npq, epq;
        logic [3:0]  eblk;
        logic [7:0]  eidx;
        logic [30:0] edata;
    } dsc_t;

    typedef struct packed {
        logic enq;  logic [30:0] enq_data;
        logic wb;   logic [3:0] wb_blk; logic [7:0] wb_idx; logic [1:0] npq, epq;
        logic bl;   logic [7:0] bl_mask;
        logic esc;  logic [3:0] esc_blk; logic [7:0] esc_idx; logic [30:0] esc_data;
        logic done; logic [1:0] err;
    } rec_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic trig_valid = 1'b0;
    logic [3:0] trig_blk = '0;
    logic [7:0] trig_idx = '0;
    logic [30:0] trig_data = '0;
    logic busy, fetch_req, fetch_ack = 1'b0;
    logic [3:0] fetch_blk;
    logic [7:0] fetch_idx;
    dsc_t drv = '0;
    logic enq_valid, wb_valid, pres_req, bl_valid, esc_valid, done, err_valid;
    logic pres_ack = 1'b0, pres_found = 1'b0;
    logic [30:0] enq_data, esc_data;
    logic [3:0] wb_blk, esc_blk;
    logic [7:0] wb_idx, esc_idx, bl_mask;
    logic [1:0] wb_npq, wb_epq, err_code;

    dsc_t dut_mem [16];
    dsc_t mdl_mem [16];
    logic found_tbl [16];
    rec_t exp_q [$];
    rec_t obs_q [$];
    int checks = 0, failures = 0, done_seen = 0, cyc = 0;

    evnt_sequencer uut (
        .clk(clk), .rst_n(rst_n),
        .trig_valid(trig_valid), .trig_blk(trig_blk), .trig_idx(trig_idx), .trig_data(trig_data),
        .busy(busy), .fetch_req(fetch_req), .fetch_blk(fetch_blk), .fetch_idx(fetch_idx),
        .fetch_ack(fetch_ack),
        .desc_valid(drv.vld), .desc_enq(drv.enq), .desc_silent(drv.sil), .desc_direct(drv.dir),
        .desc_backlog(drv.bkl), .desc_escalate(drv.esc), .desc_uncond(drv.unc),
        .desc_format(drv.fmt), .desc_prio(drv.prio), .desc_npq(drv.npq), .desc_epq(drv.epq),
        .desc_esc_blk(drv.eblk), .desc_esc_idx(drv.eidx), .desc_esc_data(drv.edata),
        .enq_valid(enq_valid), .enq_data(enq_data),
        .wb_valid(wb_valid), .wb_blk(wb_blk), .wb_idx(wb_idx), .wb_npq(wb_npq), .wb_epq(wb_epq),
        .pres_req(pres_req), .pres_ack(pres_ack), .pres_found(pres_found),
        .bl_valid(bl_valid), .bl_mask(bl_mask),
        .esc_valid(esc_valid), .esc_blk(esc_blk), .esc_idx(esc_idx), .esc_data(esc_data),
        .done(done), .err_valid(err_valid), .err_code(err_code)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Responders, store update and strobe monitor, all at the falling edge
    always @(negedge clk) begin
        rec_t r;
        if (fetch_req && !fetch_ack) begin
            fetch_ack = 1'b1;
            drv = dut_mem[fetch_idx[3:0]];
        end else begin
            fetch_ack = 1'b0;
        end
        if (pres_req && !pres_ack) begin
            pres_ack = 1'b1;
            pres_found = found_tbl[fetch_idx[3:0]];
        end else begin
            pres_ack = 1'b0;
        end
        if (rst_n) begin
            r = '0;
            if (enq_valid) begin r.enq = 1'b1; r.enq_data = enq_data; end
            if (wb_valid) begin
                r.wb = 1'b1; r.wb_blk = wb_blk; r.wb_idx = wb_idx; r.npq = wb_npq; r.epq = wb_epq;
                dut_mem[wb_idx[3:0]].npq = wb_npq;
                dut_mem[wb_idx[3:0]].epq = wb_epq;
            end
            if (bl_valid) begin r.bl = 1'b1; r.bl_mask = bl_mask; end
            if (esc_valid) begin
                r.esc = 1'b1; r.esc_blk = esc_blk; r.esc_idx = esc_idx; r.esc_data = esc_data;
            end
            if (done) begin r.done = 1'b1; done_seen++; end
            if (err_valid) r.err = err_code;
            if (r != '0) obs_q.push_back(r);
        end
    end

    // Watchdog: an expired run is a failed check and still reports
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++; failures++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic put(input int i, input dsc_t d, input logic f);
        dut_mem[i] = d; mdl_mem[i] = d; found_tbl[i] = f;
    endtask

    function automatic void push_nz(input rec_t r);
        if (r != '0) exp_q.push_back(r);
    endfunction

    // Behavioural model of one trigger: one record per strobe-producing stage
    task automatic model(input logic [3:0] blk0, input logic [7:0] idx0, input logic [30:0] d0);
        logic [3:0] blk = blk0;
        logic [7:0] idx = idx0;
        logic [30:0] data = d0;
        bit deep = 0;
        for (int step = 0; step < 2; step++) begin
            dsc_t ds = mdl_mem[idx[3:0]];
            rec_t r = '0;
            logic [1:0] nx;
            bit go;
            if (!ds.vld) begin r.done = 1; r.err = 2'd1; push_nz(r); return; end
            if (ds.enq) begin r.enq = 1; r.enq_data = data; end
            if (!ds.sil) begin
                if (!ds.fmt && ds.prio == 8'hFF) begin r.done = 1; push_nz(r); return; end
                if (!ds.dir) begin
                    nx = {1'b1, ds.npq[1] | ds.npq[0]};
                    go = (ds.npq == 2'b00);
                    if (nx != ds.npq) begin
                        r.wb = 1; r.wb_blk = blk; r.wb_idx = idx; r.npq = nx; r.epq = ds.epq;
                        ds.npq = nx; mdl_mem[idx[3:0]].npq = nx;
                    end
                    if (!go) begin r.done = 1; push_nz(r); return; end
                end
                push_nz(r); r = '0;
                if (found_tbl[idx[3:0]]) begin r.done = 1; push_nz(r); return; end
                if (ds.bkl) begin
                    if (ds.fmt) begin r.done = 1; r.err = 2'd2; push_nz(r); return; end
                    r.bl = 1;
                    r.bl_mask = (ds.prio < 8) ? (8'h80 >> ds.prio) : 8'h00;
                end
            end
            push_nz(r); r = '0;
            if (!ds.esc) begin r.done = 1; push_nz(r); return; end
            go = ds.unc;
            if (!ds.unc) begin
                nx = {1'b1, ds.epq[1] | ds.epq[0]};
                go = (ds.epq == 2'b00);
                if (nx != ds.epq) begin
                    r.wb = 1; r.wb_blk = blk; r.wb_idx = idx; r.npq = ds.npq; r.epq = nx;
                    mdl_mem[idx[3:0]].epq = nx;
                end
            end
            if (!go) begin r.done = 1; push_nz(r); return; end
            if (deep) begin r.done = 1; r.err = 2'd3; push_nz(r); return; end
            r.esc = 1; r.esc_blk = ds.eblk; r.esc_idx = ds.eidx; r.esc_data = ds.edata;
            push_nz(r);
            deep = 1; blk = ds.eblk; idx = ds.eidx; data = ds.edata;
        end
    endtask

    task automatic check(input string tag, input logic ok, input logic [255:0] act,
                         input logic [255:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one trigger, wait for its end, compare monitored records
    task automatic run(input string tag, input logic [3:0] blk, input logic [7:0] idx,
                       input logic [30:0] data, input bit extra);
        int start = done_seen;
        int n;
        exp_q.delete(); obs_q.delete();
        model(blk, idx, data);
        @(negedge clk);
        trig_valid = 1'b1; trig_blk = blk; trig_idx = idx; trig_data = data;
        @(negedge clk);
        if (extra) begin
            trig_idx = 8'd0; trig_data = 31'h7777;
            @(negedge clk);
        end
        trig_valid = 1'b0;
        for (int w = 0; w < 300 && done_seen == start; w++) @(negedge clk);
        repeat (3) @(negedge clk);
        n = exp_q.size();
        check({tag, " count"}, obs_q.size() == n, obs_q.size(), n);
        for (int k = 0; k < n; k++) begin
            rec_t o = (k < obs_q.size()) ? obs_q[k] : '0;
            check(tag, o == exp_q[k], o, exp_q[k]);
        end
    endtask

    initial begin
        dsc_t d;
        for (int i = 0; i < 16; i++) put(i, '0, 1'b0);
        repeat (4) @(negedge clk);
        // R12: idle state after reset
        check("R12 reset", {busy, fetch_req, pres_req, enq_valid, wb_valid, bl_valid,
                            esc_valid, done, err_valid} == '0,
              {busy, fetch_req, pres_req, enq_valid, wb_valid, bl_valid, esc_valid, done, err_valid},
              0);
        rst_n = 1'b1;

        // R1: invalid descriptor at index 0
        run("R1 invalid", 4'd0, 8'd0, 31'h11, 0);

        // R2 / R8: queue then found
        d = '0; d.vld = 1; d.enq = 1; d.dir = 1; d.prio = 8'd3;
        put(1, d, 1'b1);
        run("R2 R8 enq found", 4'd0, 8'd1, 31'h1234567, 0);
        // R12: second trigger while busy is ignored
        run("R12 busy trigger", 4'd0, 8'd1, 31'h2222, 1);

        // R3 / R10: silent unconditional escalation to index 3 (block 2)
        d = '0; d.vld = 1; d.enq = 1; d.sil = 1; d.esc = 1; d.unc = 1;
        d.eblk = 4'd2; d.eidx = 8'd3; d.edata = 31'h55;
        put(2, d, 1'b0);
        d = '0; d.vld = 1; d.dir = 1; d.prio = 8'd1;
        put(3, d, 1'b1);
        run("R3 R10 silent escalate", 4'd0, 8'd2, 31'h99, 0);

        // R4: masked priority, coalescing enabled but never reached
        d = '0; d.vld = 1; d.prio = 8'hFF;
        put(4, d, 1'b1);
        run("R4 masked", 4'd0, 8'd4, 31'h4, 0);

        // R5: notification state 00 -> 10 -> 11 -> 11
        d = '0; d.vld = 1; d.prio = 8'd2;
        put(5, d, 1'b1);
        run("R5 pq 00", 4'd0, 8'd5, 31'h5, 0);
        run("R5 pq 10", 4'd0, 8'd5, 31'h5, 0);
        run("R5 pq 11", 4'd0, 8'd5, 31'h5, 0);
        // R5: state 01 steps to 11 and stops
        d.npq = 2'b01;
        put(6, d, 1'b1);
        run("R5 pq 01", 4'd0, 8'd6, 31'h6, 0);

        // R2 / R5: queue and write-back in the same cycle
        d = '0; d.vld = 1; d.enq = 1; d.prio = 8'd0;
        put(7, d, 1'b1);
        run("R2 R5 same cycle", 4'd0, 8'd7, 31'h7ABC, 0);

        // R6: backlog of priority 5 and 0
        d = '0; d.vld = 1; d.dir = 1; d.bkl = 1; d.prio = 8'd5;
        put(8, d, 1'b0);
        run("R6 backlog p5", 4'd0, 8'd8, 31'h8, 0);
        d.prio = 8'd0;
        put(8, d, 1'b0);
        run("R6 backlog p0", 4'd0, 8'd8, 31'h8, 0);

        // R7: backlog with format 1
        d = '0; d.vld = 1; d.dir = 1; d.bkl = 1; d.fmt = 1; d.prio = 8'd0;
        put(9, d, 1'b0);
        run("R7 backlog fmt1", 4'd0, 8'd9, 31'h9, 0);

        // R9: gated escalation, 00 passes with write-back, 10 stops
        d = '0; d.vld = 1; d.dir = 1; d.esc = 1; d.prio = 8'd4;
        d.eidx = 8'd10; d.edata = 31'h1234;
        put(11, d, 1'b0);
        d = '0; d.vld = 1; d.dir = 1; d.prio = 8'd4;
        put(10, d, 1'b1);
        run("R9 R10 esc gate 00", 4'd0, 8'd11, 31'hB, 0);
        run("R9 esc gate 10", 4'd0, 8'd11, 31'hB, 0);

        // R11: escalation from an escalated sequence
        d = '0; d.vld = 1; d.dir = 1; d.esc = 1; d.unc = 1; d.prio = 8'd1;
        d.eidx = 8'd13; d.edata = 31'hD;
        put(12, d, 1'b0);
        d = '0; d.vld = 1; d.sil = 1; d.esc = 1; d.unc = 1; d.eidx = 8'd1;
        put(13, d, 1'b0);
        run("R11 depth", 4'd0, 8'd12, 31'hC, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule